// File: doc/BRIEF.md
# Multi-Scheme Centralized Bus Arbiter

This block decides which of a fixed set of bus masters may drive a shared bus. Each master has a request input and a grant output. All masters share one busy line, which the current owner holds high for as long as its transfer lasts. A centralized controller issues at most one grant at a time. It issues a grant only when the bus is free, and it keeps that grant until the owner lets go of busy.

A static mode input chooses how the next owner is found.

- **Chained mode:** the requests are ORed into one common line. A grant token travels along the masters in index order, and the first requesting master stops it.
- **Polled mode:** the controller puts one master's address code on a poll bus on each clock. The polled master wins if it is requesting at that moment.
- **Parallel mode:** each master has its own request line, and a priority decoder picks the highest-priority request.

Index 0 is the highest priority in every mode. The fourth mode code issues no grants. The mode may change only while the bus is idle.

Top module: `arb_multi_scheme`

## Requirements
- R1: A synchronous active-low reset clears every grant and sets the poll address to 0 at the next rising edge. This also applies when a master owns the bus.
- R2: The grant vector never has more than one bit set.
- R3: No new grant is issued while busy is high or while a grant is outstanding. An outstanding grant never moves directly to another master.
- R4: Once granted, the grant stays unchanged while busy is high. It clears at the first rising edge that samples busy low after busy was seen high. A new grant can follow at the edge after that.
- R5: Chained mode is mode_sel = 0. When the bus is free, the requesting master with the lowest index receives the grant at the next edge.
- R6: Polled mode is mode_sel = 1. While the bus is free and the polled master is not requesting, poll_addr advances by one on each edge and wraps from N-1 to 0. In the other modes, poll_addr stays at 0.
- R7: In polled mode, a master whose index is on poll_addr and which is requesting while the bus is free receives the grant at that edge. poll_addr then holds while the bus is owned.
- R8: When a grant is released, poll_addr returns to 0, so the next poll scan starts from the highest priority.
- R9: Parallel mode is mode_sel = 2. When the bus is free, the lowest-index active request receives the grant at the next edge.
- R10: mode_sel = 3 issues no grant, whatever the requests are.
- R11: In chained and parallel modes, the grant appears one cycle after a free-bus edge that samples any request. No extra cycles are added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | 0 chained, 1 polled, 2 parallel, 3 no grant |
| req | input | N | Request line for each master |
| busy_in | input | 1 | Shared busy line, driven high by the owner |
| gnt | output | N | One-hot registered grant |
| poll_addr | output | max(1, ceil(log2 N)) | Address code of the master being polled |

## Verification
Each result is due at a fixed edge:

- A grant appears one edge after a free-bus edge that samples the winning request.
- A grant clears one edge after busy is sampled low.
- poll_addr moves on every free edge in polled mode.

The bench drives inputs on the falling edge. It advances its own cycle model just after each rising edge and compares both outputs at the next falling edge, so every comparison falls exactly one register stage after its cause. Directed sequences pin down each step of the chain, the poll scan and its wrap, and the release timing. Random phases then cover all modes with owners that hold busy for varying lengths.

// File: rtl/arb_pkg.sv
// Shared definitions for the multi-scheme bus arbiter.
package arb_pkg;

    // Arbitration scheme selected by the static mode input.
    typedef enum logic [1:0] {
        ARB_CHAIN = 2'd0,
        ARB_POLL  = 2'd1,
        ARB_PAR   = 2'd2,
        ARB_NONE  = 2'd3
    } arb_mode_e;

endpackage

// File: rtl/arb_chain.sv
// Serial grant chain.
// What it does: the requests are ORed into one common line. The grant token
// enters at master 0 and ripples upward until a requesting master takes it.
// Assumes: the caller gates 'enable' with "bus free and chained mode".
module arb_chain #(
    parameter int N = 5
) (
    input  logic         enable,
    input  logic [N-1:0] req,
    output logic [N-1:0] win
);

    logic         common_req;
    logic [N-1:0] token;

    // The shared request line seen by the controller.
    assign common_req = |req;
    assign token[0]   = enable & common_req;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_link
            // A stage keeps the token if its master is requesting.
            assign win[gi] = token[gi] & req[gi];
            if (gi < N - 1) begin : g_pass
                // Otherwise it passes the token on to the next stage.
                assign token[gi+1] = token[gi] & ~req[gi];
            end
        end
    endgenerate

endmodule

// File: rtl/arb_fixed_prio.sv
// Parallel fixed-priority decoder.
// What it does: it selects the lowest-index active request.
// Assumes: the caller gates 'enable' with "bus free and parallel mode".
module arb_fixed_prio #(
    parameter int N = 5
) (
    input  logic         enable,
    input  logic [N-1:0] req,
    output logic [N-1:0] win
);

    // Scan from the top index down, so the lowest active index is the last one written.
    always_comb begin
        win = '0;
        if (enable) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (req[i]) begin
                    win    = '0;
                    win[i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/arb_poll_ctrl.sv
// Poll address generator.
// What it does: it drives an address code on every clock while scanning. The
// code advances and wraps when the polled master is idle, and it reports a hit
// when the polled master is requesting.
// Assumes: 'park' and 'scan_en' are never high together.
module arb_poll_ctrl #(
    parameter int N  = 5,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_en,
    input  logic          park,
    input  logic [N-1:0]  req,
    output logic [AW-1:0] addr,
    output logic [N-1:0]  win
);

    localparam logic [AW-1:0] LAST = AW'(N - 1);

    logic          hit;
    logic [AW-1:0] addr_step;

    // The polled master answers if its request is high.
    assign hit       = scan_en & req[addr];
    assign addr_step = (addr == LAST) ? '0 : addr + 1'b1;

    // Address register: reset or park to 0, advance on a miss, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (park) begin
            addr <= '0;
        end else if (scan_en && !req[addr]) begin
            addr <= addr_step;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_dec
            // Decode the hit onto the matching master.
            assign win[gi] = hit & (addr == AW'(gi));
        end
    endgenerate

    p_poll_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !park && !req[addr]) |=>
            (addr == (($past(addr) == LAST) ? '0 : $past(addr) + 1'b1)));

    p_poll_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST);

    p_poll_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en && !park) |=> $stable(addr));

endmodule

// File: rtl/arb_multi_scheme.sv
// Centralized bus arbiter with three selectable schemes.
// What it does: it registers a one-hot grant chosen by the chained, polled or
// parallel scheme. The grant is issued only while the bus is free, and it is
// held until the owner raises and then drops the shared busy line.
// Assumes: mode_sel changes only while the bus is idle, and the owner raises
// busy_in after it is granted.
module arb_multi_scheme
    import arb_pkg::*;
#(
    parameter int N = 5,
    parameter int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic [N-1:0]  req,
    input  logic          busy_in,
    output logic [N-1:0]  gnt,
    output logic [AW-1:0] poll_addr
);

    arb_mode_e    mode;
    logic [N-1:0] gnt_q;
    logic         seen_q;
    logic         bus_free;
    logic         release_now;
    logic [N-1:0] win_chain, win_poll, win_par, cand;

    assign mode = arb_mode_e'(mode_sel);

    // The bus is free when no grant is held and nobody drives busy.
    assign bus_free    = (gnt_q == '0) && !busy_in;
    // The owner has finished: busy was seen high and is now low.
    assign release_now = (gnt_q != '0) && seen_q && !busy_in;

    arb_chain #(.N(N)) u_chain (
        .enable (bus_free && (mode == ARB_CHAIN)),
        .req    (req),
        .win    (win_chain)
    );

    arb_poll_ctrl #(.N(N), .AW(AW)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_en (bus_free && (mode == ARB_POLL)),
        .park    ((mode != ARB_POLL) || release_now),
        .req     (req),
        .addr    (poll_addr),
        .win     (win_poll)
    );

    arb_fixed_prio #(.N(N)) u_par (
        .enable (bus_free && (mode == ARB_PAR)),
        .req    (req),
        .win    (win_par)
    );

    // Take the candidate produced by the selected scheme.
    always_comb begin
        unique case (mode)
            ARB_CHAIN: cand = win_chain;
            ARB_POLL:  cand = win_poll;
            ARB_PAR:   cand = win_par;
            default:   cand = '0;
        endcase
    end

    // Grant register: issue when free, track busy, release after busy falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (gnt_q != '0) begin
            if (busy_in) begin
                seen_q <= 1'b1;
            end else if (seen_q) begin
                gnt_q  <= '0;
                seen_q <= 1'b0;
            end
        end else if (bus_free) begin
            gnt_q <= cand;
        end
    end

    assign gnt = gnt_q;

    p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_q));

    p_no_grant_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q == '0 && busy_in) |=> (gnt_q == '0));

    p_no_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != '0) |=> (gnt_q == '0 || gnt_q == $past(gnt_q)));

    p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != '0 && busy_in) |=> $stable(gnt_q));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != '0 && $fell(busy_in)) |=> (gnt_q == '0));

    p_chain_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && mode == ARB_CHAIN && req != '0) |=>
            (gnt_q == ($past(req) & (~$past(req) + 1'b1))));

    p_poll_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_now |=> (poll_addr == '0));

    p_par_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && mode == ARB_PAR && req != '0) |=>
            (gnt_q == ($past(req) & (~$past(req) + 1'b1))));

    p_none_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q == '0 && mode == ARB_NONE) |=> (gnt_q == '0));

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_free && (mode == ARB_PAR || mode == ARB_CHAIN) && req != '0) |=>
            (gnt_q != '0));

endmodule

// File: tb/arb_multi_scheme_test.sv
// Self-checking bench for arb_multi_scheme.
module arb_multi_scheme_test;

    localparam int NM      = 5;
    localparam int AWB     = 3;
    localparam int CLK_PER = 10;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [1:0]     mode_sel;
    logic [NM-1:0]  req;
    logic           busy_in;
    logic [NM-1:0]  gnt;
    logic [AWB-1:0] poll_addr;

    int total = 0;
    int bad   = 0;

    // Reference model state.
    logic [NM-1:0]  e_gnt  = '0;
    logic [AWB-1:0] e_pa   = '0;
    logic           e_seen = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    arb_multi_scheme #(.N(NM)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .req       (req),
        .busy_in   (busy_in),
        .gnt       (gnt),
        .poll_addr (poll_addr)
    );

    // Lowest set bit of r, as a one-hot value.
    function automatic logic [NM-1:0] lowest(input logic [NM-1:0] r);
        for (int i = 0; i < NM; i++) begin
            if (r[i]) return NM'(1) << i;
        end
        return '0;
    endfunction

    // Requirement tag for the model comparison in each mode.
    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0:    return "R5";
            2'd1:    return "R6/R7";
            2'd2:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one rising edge, using the inputs applied at the last falling edge.
    task automatic model_step();
        if (!rst_n) begin
            e_gnt = '0; e_pa = '0; e_seen = 1'b0;
        end else if (e_gnt != '0) begin
            if (busy_in) e_seen = 1'b1;
            else if (e_seen) begin
                e_gnt = '0; e_seen = 1'b0; e_pa = '0;
            end
        end else if (!busy_in) begin
            case (mode_sel)
                2'd0, 2'd2: e_gnt = lowest(req);
                2'd1: begin
                    if (req[e_pa]) e_gnt = NM'(1) << e_pa;
                    else e_pa = (e_pa == AWB'(NM - 1)) ? '0 : e_pa + 1'b1;
                end
                default: ;
            endcase
        end
        if (rst_n && mode_sel != 2'd1) e_pa = '0;
    endtask

    // One clock cycle: the edge, the model update, then a comparison at the falling edge.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({mode_tag(mode_sel), " model gnt"}, 32'(gnt), 32'(e_gnt));
        chk({mode_tag(mode_sel), " model poll"}, 32'(poll_addr), 32'(e_pa));
        total++;
        if (!$onehot0(gnt)) begin
            bad++;
            $display("FAIL R2 actual=%0h expected=one-hot or zero", gnt);
        end
    endtask

    // Let the owner hold busy for one cycle, then release the bus.
    task automatic own_and_release();
        busy_in = 1'b1; cyc();
        busy_in = 1'b0; cyc();
    endtask

    initial begin
        #(CLK_PER * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hold;
        bit started;
        void'($urandom(32'd2718));
        rst_n = 1'b0; mode_sel = 2'd2; req = '1; busy_in = 1'b0;
        @(negedge clk);
        cyc(); cyc();
        chk("R1 reset gnt", 32'(gnt), 0);
        chk("R1 reset poll", 32'(poll_addr), 0);

        // Parallel mode: priority, latency, hold and release.
        rst_n = 1'b1; req = 5'b10100; cyc();
        chk("R9 R11 parallel pick", 32'(gnt), 32'h04);
        busy_in = 1'b1; req = 5'b00001; cyc();
        chk("R4 hold while busy", 32'(gnt), 32'h04);
        cyc();
        chk("R3 no switch while owned", 32'(gnt), 32'h04);
        busy_in = 1'b0; cyc();
        chk("R4 release after busy low", 32'(gnt), 0);
        cyc();
        chk("R9 next pending request", 32'(gnt), 32'h01);
        own_and_release();
        req = '0; cyc();

        // Busy held by another party: no grant.
        busy_in = 1'b1; req = 5'b00010; cyc(); cyc();
        chk("R3 no grant while busy", 32'(gnt), 0);
        busy_in = 1'b0; cyc();
        chk("R3 grant once free", 32'(gnt), 32'h02);
        own_and_release();
        req = '0; cyc();

        // Chained mode.
        mode_sel = 2'd0; req = 5'b11000; cyc();
        chk("R5 chain nearest requester", 32'(gnt), 32'h08);
        own_and_release();
        req = 5'b00110; cyc();
        chk("R5 R11 chain lowest index", 32'(gnt), 32'h02);
        own_and_release();
        req = '0; cyc();

        // Polled mode: scan up to master 4.
        mode_sel = 2'd1; req = 5'b10000;
        for (int k = 1; k <= 4; k++) begin
            cyc();
            chk("R6 poll advance", 32'(poll_addr), 32'(k));
        end
        chk("R7 no grant before hit", 32'(gnt), 0);
        cyc();
        chk("R7 polled grant", 32'(gnt), 32'h10);
        chk("R7 poll addr at hit", 32'(poll_addr), 4);
        busy_in = 1'b1; cyc();
        chk("R7 poll held while owned", 32'(poll_addr), 4);
        busy_in = 1'b0; req = '0; cyc();
        chk("R4 polled release", 32'(gnt), 0);
        chk("R8 poll back to zero", 32'(poll_addr), 0);
        for (int k = 1; k <= 5; k++) begin
            cyc();
            chk("R6 poll wrap sequence", 32'(poll_addr), 32'(k % NM));
        end

        // Mode with no grant.
        mode_sel = 2'd3; req = '1; cyc(); cyc(); cyc();
        chk("R10 no grant in mode 3", 32'(gnt), 0);
        chk("R6 poll parked outside polled mode", 32'(poll_addr), 0);

        // Reset during ownership.
        req = '0; mode_sel = 2'd2; cyc();
        req = 5'b00100; cyc();
        busy_in = 1'b1; cyc();
        rst_n = 1'b0; cyc();
        chk("R1 reset clears owner", 32'(gnt), 0);
        rst_n = 1'b1; busy_in = 1'b0; req = '0; cyc();

        // Random phase; the mode changes only while the bus is idle.
        hold = 0; started = 0;
        for (int n = 0; n < 4000; n++) begin
            req = (($urandom % 4) == 0) ? '0 : NM'($urandom);
            if (gnt != '0 && !started) begin
                busy_in = 1'b1; hold = $urandom % 4; started = 1;
            end else if (started && busy_in) begin
                if (hold == 0) busy_in = 1'b0;
                else hold--;
            end
            if (gnt == '0) started = 0;
            if (e_gnt == '0 && !busy_in && ($urandom % 8) == 0)
                mode_sel = 2'($urandom);
            cyc();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule